// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between the data port of a bus master and a word-addressed memory. Two alias windows, each 32 MB, map single-bit accesses onto a backing region of 1 MB. One window serves the internal SRAM area and the other serves the on-chip peripheral area. In each window, one 32-bit word address stands for one bit of one backing word. A data write to an alias word becomes a locked read-modify-write of that backing word, which sets or clears only the chosen bit. A data read of an alias word reads the backing word and returns the chosen bit in bit 0.

Every other access passes straight through in the same cycle. This covers direct accesses to the backing regions and any other data access. Instruction fetches are never translated. A fetch that targets the peripheral area is refused with an error response and never reaches the memory.

Top module: `bitband_bridge`

## Requirements
- R1: A request that is neither an alias data access nor a refused fetch is forwarded in the same cycle. `mem_addr`, `mem_we`, `mem_wdata` and `mem_be` copy the host values, `host_ready` follows `mem_ready`, `host_rdata` follows `mem_rdata`, and `mem_lock` stays low.
- R2: The alias windows are 0x2200_0000..0x23FF_FFFF (SRAM) and 0x4200_0000..0x43FF_FFFF (peripheral), with backing bases 0x2000_0000 and 0x4000_0000. For an offset `off` into a window, the backing word is base + ((off >> 5) & ~3) and the bit index is (off >> 2) & 31.
- R3: On an alias data write, bit 0 of `host_wdata` is the new bit value (1 sets, 0 clears). The other write-data bits and `host_be` have no effect. All other bits of the backing word keep their values.
- R4: An alias data read makes exactly one memory read of the backing word and no write. It returns the addressed bit in bit 0 of `host_rdata`, with bits 31..1 zero.
- R5: During an alias sequence `mem_lock` is high on every memory phase. It stays high without a gap from the read phase through the write phase, and the write phase drives `mem_be` = 4'hF.
- R6: `host_ready` stays low while the alias sequence runs and is high for one cycle after its last memory phase completes. With no wait states, a write finishes three cycles after the request and a read finishes two cycles after it.
- R7: An instruction fetch (`host_fetch` = 1) anywhere in 0x4000_0000..0x5FFF_FFFF gets `host_err` and `host_ready` in the same cycle, and the memory sees no request.
- R8: An instruction fetch into the SRAM alias window is not translated. It is forwarded with its own address.
- R9: The two alias/backing pairs are independent. A bit written through one window leaves the other region's backing word at the same offset unchanged.
- R10: The sequencer holds each memory phase, with the same address and data, for as long as `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request valid, held until `host_ready` |
| host_we | input | 1 | Host write (1) or read (0) |
| host_fetch | input | 1 | Request is an instruction fetch |
| host_addr | input | 32 | Host byte address, word aligned |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables |
| host_ready | output | 1 | Transfer completes this cycle |
| host_rdata | output | 32 | Read data to host |
| host_err | output | 1 | Error response (refused fetch) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_lock | output | 1 | Hold the arbiter for this master |
| mem_ready | input | 1 | Memory phase completes this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions assume that the host holds the whole request steady from the cycle it raises `host_req` until the cycle `host_ready` is high. They also assume that alias addresses are word aligned. The bench keeps to this: one task drives a complete request at a falling edge and changes nothing until the ready cycle has passed a rising edge. It only builds alias addresses from a word index and a bit index. The memory model inserts wait states from a pseudo-random pattern, so each sequencer phase is exercised both with and without stalls.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS = 32'h2200_0000,
  parameter logic [31:0] PERI_BASE  = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS = 32'h4200_0000,
  parameter logic [31:0] PERI_AREA  = 32'h4000_0000,
  parameter int          ALIAS_LG2  = 25,
  parameter int          AREA_LG2   = 29,
  parameter int          DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_fetch,
  input  logic [31:0]   host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW/8-1:0] host_be,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic          host_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_be,
  output logic          mem_lock,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = $clog2(DW);
  localparam logic [31:0] WIN_MASK  = ~((32'd1 << ALIAS_LG2) - 32'd1);
  localparam logic [31:0] AREA_MASK = ~((32'd1 << AREA_LG2) - 32'd1);

  typedef enum logic [1:0] {IDLE, RD, WR, DONE} state_t;
  state_t st;

  logic [31:0]   a_addr;
  logic [BW-1:0] a_bit;
  logic          a_val, a_we, a_rbit;
  logic [DW-1:0] a_word;

  wire hit_s     = (host_addr & WIN_MASK) == SRAM_ALIAS;
  wire hit_p     = (host_addr & WIN_MASK) == PERI_ALIAS;
  wire fetch_bad = host_req & host_fetch & ((host_addr & AREA_MASK) == PERI_AREA);
  wire alias_hit = host_req & ~host_fetch & (hit_s | hit_p);
  wire is_idle   = st == IDLE;
  wire pass      = is_idle & host_req & ~alias_hit & ~fetch_bad;

  wire [31:0]   off     = host_addr - (hit_p ? PERI_ALIAS : SRAM_ALIAS);
  wire [31:0]   bk_addr = (hit_p ? PERI_BASE : SRAM_BASE) + ((off >> 5) & ~32'd3);
  wire [DW-1:0] bit_msk = {{(DW-1){1'b0}}, 1'b1} << a_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      a_addr <= '0;
      a_bit  <= '0;
      a_val  <= 1'b0;
      a_we   <= 1'b0;
      a_rbit <= 1'b0;
      a_word <= '0;
    end else begin
      case (st)
        IDLE: if (alias_hit) begin
          a_addr <= bk_addr;
          a_bit  <= off[BW+1:2];
          a_val  <= host_wdata[0];
          a_we   <= host_we;
          st     <= RD;
        end
        RD: if (mem_ready) begin
          a_rbit <= mem_rdata[a_bit];
          a_word <= a_val ? (mem_rdata | bit_msk) : (mem_rdata & ~bit_msk);
          st     <= a_we ? WR : DONE;
        end
        WR: if (mem_ready) st <= DONE;
        default: st <= IDLE;
      endcase
    end
  end

  assign mem_lock   = (st == RD) | (st == WR);
  assign mem_req    = pass | mem_lock;
  assign mem_we     = (st == WR) | (pass & host_we);
  assign mem_addr   = is_idle ? host_addr : a_addr;
  assign mem_wdata  = (st == WR) ? a_word : host_wdata;
  assign mem_be     = is_idle ? host_be : '1;
  assign host_err   = is_idle & fetch_bad;
  assign host_ready = (pass & mem_ready) | host_err | (st == DONE);
  assign host_rdata = (st == DONE) ? {{(DW-1){1'b0}}, a_rbit & ~a_we}
                    : (pass ? mem_rdata : '0);
endmodule

module bitband_bridge_chk #(
  parameter logic [31:0] SRAM_ALIAS = 32'h2200_0000,
  parameter logic [31:0] PERI_ALIAS = 32'h4200_0000,
  parameter logic [31:0] PERI_AREA  = 32'h4000_0000,
  parameter int          ALIAS_LG2  = 25,
  parameter int          AREA_LG2   = 29,
  parameter int          DW         = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_req,
  input logic            host_we,
  input logic            host_fetch,
  input logic [31:0]     host_addr,
  input logic            host_ready,
  input logic [DW-1:0]   host_rdata,
  input logic            host_err,
  input logic            mem_req,
  input logic            mem_we,
  input logic [31:0]     mem_addr,
  input logic [DW/8-1:0] mem_be,
  input logic            mem_lock,
  input logic            mem_ready
);
  localparam logic [31:0] WIN_MASK  = ~((32'd1 << ALIAS_LG2) - 32'd1);
  localparam logic [31:0] AREA_MASK = ~((32'd1 << AREA_LG2) - 32'd1);

  wire in_win  = ((host_addr & WIN_MASK) == SRAM_ALIAS) | ((host_addr & WIN_MASK) == PERI_ALIAS);
  wire in_area = (host_addr & AREA_MASK) == PERI_AREA;
  wire dalias  = host_req & ~host_fetch & in_win;

  // R1
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !dalias && !(host_fetch && in_area)) |->
      (mem_req && mem_addr == host_addr && mem_we == host_we && !mem_lock && host_ready == mem_ready));

  // R4
  alias_rd_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dalias && !host_we && host_ready) |-> (host_rdata[DW-1:1] == '0));

  // R5
  atomic_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dalias && host_we && mem_lock && mem_req && !mem_we && mem_ready) |=> (mem_lock && mem_req && mem_we));

  // R5
  lock_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && mem_we) |-> (mem_be == '1));

  // R5
  alias_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dalias && mem_req) |-> mem_lock);

  // R6
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !host_ready);

  // R6
  lock_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |=> (mem_lock || host_ready));

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !mem_ready) |=> (mem_lock && $stable(mem_addr) && $stable(mem_we)));

  // R7
  fetch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_fetch && in_area) |-> (host_err && host_ready && !mem_req));

  // R8
  fetch_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_fetch && in_win && !in_area) |-> (mem_req && mem_addr == host_addr && !host_err));
endmodule

bind bitband_bridge bitband_bridge_chk #(
  .SRAM_ALIAS(SRAM_ALIAS), .PERI_ALIAS(PERI_ALIAS), .PERI_AREA(PERI_AREA),
  .ALIAS_LG2(ALIAS_LG2), .AREA_LG2(AREA_LG2), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_fetch(host_fetch), .host_addr(host_addr), .host_ready(host_ready),
  .host_rdata(host_rdata), .host_err(host_err), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_lock(mem_lock), .mem_ready(mem_ready)
);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/100ps
module bitband_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_fetch = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic [3:0]  host_be = '0;
  logic        host_ready, host_err;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_lock, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #2.5 clk = ~clk;

  bitband_bridge u_bitband_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_fetch(host_fetch), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_be(host_be), .host_ready(host_ready), .host_rdata(host_rdata),
    .host_err(host_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_lock(mem_lock), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Memory model: word index = {region bit 30, address bits 9..2}
  logic [31:0] mem  [0:511];
  logic [31:0] refm [0:511];
  logic        stall = 1'b0, stall_on = 1'b0;
  logic [15:0] slf = 16'hACE1;
  assign mem_ready = mem_req & ~stall;
  assign mem_rdata = mem[{mem_addr[30], mem_addr[9:2]}];

  always @(posedge clk) begin
    slf   <= {slf[14:0], slf[15] ^ slf[13] ^ slf[12] ^ slf[10]};
    stall <= stall_on & slf[0];
    if (mem_req && mem_ready && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[{mem_addr[30], mem_addr[9:2]}][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  int          hs_cnt;
  logic [31:0] hs_addr [0:3];
  logic [31:0] hs_wd   [0:3];
  logic [3:0]  hs_be   [0:3];
  logic        hs_we   [0:3];
  logic        hs_lock [0:3];
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (hs_cnt < 4) begin
        hs_addr[hs_cnt] = mem_addr; hs_wd[hs_cnt] = mem_wdata; hs_be[hs_cnt] = mem_be;
        hs_we[hs_cnt] = mem_we; hs_lock[hs_cnt] = mem_lock;
      end
      hs_cnt++;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic we, input logic fe,
                      input logic [31:0] wd, input logic [3:0] be,
                      output logic [31:0] rd, output logic er, output int waits);
    @(negedge clk);
    host_req = 1'b1; host_addr = a; host_we = we; host_fetch = fe;
    host_wdata = wd; host_be = be; hs_cnt = 0; waits = 0;
    #1;
    while (!host_ready && waits < 1000) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 1000) check("watchdog host_ready", 32'd0, 32'd1);
    rd = host_rdata; er = host_err;
    @(posedge clk); #1;
  endtask

  task automatic release_bus();
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; host_fetch = 1'b0;
  endtask

  function automatic int widx(input logic [31:0] a);
    return {23'd0, a[30], a[9:2]};
  endfunction

  function automatic logic [31:0] alias_of(input logic peri, input int w, input int b);
    return (peri ? 32'h4200_0000 : 32'h2200_0000) + w * 128 + b * 4;
  endfunction

  task automatic direct_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] rd; logic er; int wt;
    xfer(a, 1'b1, 1'b0, d, be, rd, er, wt);
    for (int b = 0; b < 4; b++)
      if (be[b]) refm[widx(a)][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic direct_rd_chk(input string req, input logic [31:0] a);
    logic [31:0] rd; logic er; int wt;
    xfer(a, 1'b0, 1'b0, 32'h0, 4'hF, rd, er, wt);
    check(req, rd, refm[widx(a)]);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
    check("R5 reset mem_lock", {31'd0, mem_lock}, 32'd0);
    check("R6 reset host_ready", {31'd0, host_ready}, 32'd0);
  endtask

  task automatic t_direct();
    logic [31:0] rd; logic er; int wt;
    direct_wr(32'h2000_0010, 32'hDEAD_BEEF, 4'hF);
    check("R1 direct write handshakes", hs_cnt, 1);
    check("R1 direct write lock", {31'd0, hs_lock[0]}, 32'd0);
    check("R1 direct write strobes", {28'd0, hs_be[0]}, 32'hF);
    direct_wr(32'h4000_0020, 32'h1122_3344, 4'hF);
    direct_wr(32'h4000_0020, 32'hAAAA_BBBB, 4'b0101);
    xfer(32'h4000_0020, 1'b0, 1'b0, 32'h0, 4'hF, rd, er, wt);
    check("R1 partial strobe read", rd, refm[widx(32'h4000_0020)]);
    check("R1 direct read latency", wt, 0);
    direct_rd_chk("R1 direct readback", 32'h2000_0010);
  endtask

  task automatic t_alias_set();
    logic [31:0] rd; logic er; int wt;
    direct_wr(32'h2000_0040, 32'h0000_0000, 4'hF);
    xfer(alias_of(1'b0, 16, 5), 1'b1, 1'b0, 32'h0000_0001, 4'h1, rd, er, wt);
    refm[widx(32'h2000_0040)][5] = 1'b1;
    check("R2 alias address", alias_of(1'b0, 16, 5), 32'h2200_0814);
    check("R6 alias write latency", wt, 3);
    check("R2 read phase addr", hs_addr[0], 32'h2000_0040);
    check("R2 write phase addr", hs_addr[1], 32'h2000_0040);
    check("R5 lock both phases", {30'd0, hs_lock[0], hs_lock[1]}, 32'd3);
    check("R5 write be", {28'd0, hs_be[1]}, 32'hF);
    check("R3 written word", hs_wd[1], 32'h0000_0020);
    direct_rd_chk("R3 set readback", 32'h2000_0040);
  endtask

  task automatic t_alias_clear();
    logic [31:0] rd; logic er; int wt;
    direct_wr(32'h2000_0044, 32'hFFFF_FFFF, 4'hF);
    xfer(alias_of(1'b0, 17, 31), 1'b1, 1'b0, 32'hFFFF_FFFE, 4'hF, rd, er, wt);
    refm[widx(32'h2000_0044)][31] = 1'b0;
    check("R3 clear ignores upper wdata", hs_wd[1], 32'h7FFF_FFFF);
    direct_rd_chk("R3 clear readback", 32'h2000_0044);
    xfer(alias_of(1'b0, 17, 0), 1'b1, 1'b0, 32'h0000_0000, 4'h0, rd, er, wt);
    refm[widx(32'h2000_0044)][0] = 1'b0;
    direct_rd_chk("R3 zero strobes still clear", 32'h2000_0044);
  endtask

  task automatic t_alias_read();
    logic [31:0] rd; logic er; int wt;
    direct_wr(32'h2000_0080, 32'h8000_0004, 4'hF);
    xfer(alias_of(1'b0, 32, 2), 1'b0, 1'b0, 32'hFFFF_FFFF, 4'hF, rd, er, wt);
    check("R4 read set bit", rd, 32'd1);
    check("R4 single handshake", hs_cnt, 1);
    check("R4 no write phase", {31'd0, hs_we[0]}, 32'd0);
    check("R6 alias read latency", wt, 2);
    xfer(alias_of(1'b0, 32, 3), 1'b0, 1'b0, 32'h0, 4'hF, rd, er, wt);
    check("R4 read clear bit", rd, 32'd0);
    xfer(alias_of(1'b0, 32, 31), 1'b0, 1'b0, 32'h0, 4'hF, rd, er, wt);
    check("R4 read bit 31", rd, 32'd1);
    direct_rd_chk("R4 backing unchanged", 32'h2000_0080);
  endtask

  task automatic t_periph();
    logic [31:0] rd; logic er; int wt;
    direct_wr(32'h2000_0100, 32'h0000_0000, 4'hF);
    direct_wr(32'h4000_0100, 32'h0000_0000, 4'hF);
    xfer(alias_of(1'b1, 64, 9), 1'b1, 1'b0, 32'h1, 4'hF, rd, er, wt);
    refm[widx(32'h4000_0100)][9] = 1'b1;
    check("R9 peripheral backing addr", hs_addr[0], 32'h4000_0100);
    direct_rd_chk("R9 peripheral word set", 32'h4000_0100);
    direct_rd_chk("R9 sram word untouched", 32'h2000_0100);
  endtask

  task automatic t_fetch();
    logic [31:0] rd; logic er; int wt;
    xfer(32'h4000_0100, 1'b0, 1'b1, 32'h0, 4'hF, rd, er, wt);
    check("R7 fetch peri err", {31'd0, er}, 32'd1);
    check("R7 fetch peri no mem", hs_cnt, 0);
    check("R7 fetch peri same cycle", wt, 0);
    xfer(alias_of(1'b1, 1, 1), 1'b0, 1'b1, 32'h0, 4'hF, rd, er, wt);
    check("R7 fetch peri alias err", {31'd0, er}, 32'd1);
    check("R7 fetch peri alias no mem", hs_cnt, 0);
    xfer(32'h2200_0814, 1'b0, 1'b1, 32'h0, 4'hF, rd, er, wt);
    check("R8 sram alias fetch err", {31'd0, er}, 32'd0);
    check("R8 sram alias fetch handshakes", hs_cnt, 1);
    check("R8 sram alias fetch addr", hs_addr[0], 32'h2200_0814);
    check("R8 sram alias fetch unlocked", {31'd0, hs_lock[0]}, 32'd0);
  endtask

  task automatic t_stall_mix();
    logic [31:0] rd; logic er; int wt;
    logic [31:0] s = 32'h1357_9BDF;
    stall_on = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic peri; int w, b, ix; logic [31:0] a;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      peri = s[0]; w = int'(s[11:4]); b = int'(s[16:12]);
      ix = {23'd0, peri, w[7:0]};
      a = (peri ? 32'h4000_0000 : 32'h2000_0000) + w * 4;
      case (s[19:18])
        2'd0: direct_wr(a, s ^ 32'h5A5A_0F0F, s[23:20]);
        2'd1: begin
          xfer(alias_of(peri, w, b), 1'b1, 1'b0, {s[31:1], s[24]}, s[23:20], rd, er, wt);
          refm[ix][b] = s[24];
          check("R10 stalled rmw handshakes", hs_cnt, 2);
        end
        default: begin
          xfer(alias_of(peri, w, b), 1'b0, 1'b0, s, 4'hF, rd, er, wt);
          check("R10 stalled alias read", rd, {31'd0, refm[ix][b]});
        end
      endcase
    end
    stall_on = 1'b0;
    for (int i = 0; i < 512; i++) begin
      n_cmp++;
      if (mem[i] !== refm[i]) begin
        n_bad++;
        $display("FAIL R3 word %0d after mix: actual %h expected %h", i, mem[i], refm[i]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = '0; refm[i] = '0; end
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_direct();
    t_alias_set();
    t_alias_clear();
    t_alias_read();
    t_periph();
    t_fetch();
    t_stall_mix();
    release_bus();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule